// File: doc/BRIEF.md
# Stacked-Register Execution Core

This block is a compact 16-bit execution core with four general registers. Each register is the visible top of its own small hardware stack. An instruction names a source register and a second register that is both an operand and the destination. It carries one stack-move flag per register and an 8-bit operation field. In a single clock the core decodes the word, reads both operands, evaluates the ALU function and writes the destination. In the same clock it pushes the old destination value and/or pops the source register's stack, as the flags request.

The core fetches from an external program store through two read ports. One returns the word at the program counter. The other returns the word after it, so that a 16-bit constant placed in-line can be loaded in the same cycle as its opcode. A 4-bit signed constant can also replace the source operand of any ALU operation. Stack overflow and underflow never wrap the stack. Each raises a sticky flag.

Top module: `stkreg_core`

## Requirements
- R1: While `rst` is high and right after its release, `prog_addr` is 0, all four registers read 0, and both status flags are 0.
- R2: Instruction word layout: bits [15:8] operation, bits [7:4] stack-move flags for registers 3..0, bits [3:2] source register, bits [1:0] destination register. An operation byte of 0x00..0x07 is a register-form ALU op whose low three bits select MOV=0, ADD=1, SUB(dst-src)=2, AND=3, OR=4, XOR=5, SHL=6, SHR=7. Shifts are logical, by the source's low four bits. The result goes to the destination.
- R3: An operation byte with bit 7 set is a short-constant form. Bits [6:3] are a 4-bit two's-complement constant, sign-extended, that replaces the source operand. Bits [2:0] select the ALU function as in R2.
- R4: Operation byte 0x08 loads the word at `prog_addr`+1 into the destination. That word is never executed, and `prog_addr` advances by 2.
- R5: When the destination's stack-move flag is set on a writing instruction, the previous destination value is pushed and the new result becomes visible. Without the flag, the destination is simply overwritten.
- R6: In register form, when the source's flag is set and source differs from destination, that register takes its stack's top entry after its value is read. This can happen in the same cycle as a push onto the destination.
- R7: When source and destination name the same register and its flag is set, only the push takes place.
- R8: Flags of registers that are neither source nor destination are ignored. The short-constant and in-line load forms never pop the source.
- R9: Each stack holds 8 entries. A push onto a full stack discards the pushed value, keeps the stack contents, still writes the register, and sets the sticky overflow flag.
- R10: A pop from an empty stack leaves the register unchanged and sets the sticky underflow flag.
- R11: Any other operation byte (0x09..0x7F) changes no register, stack or flag, and `prog_addr` advances by 1.
- R12: Every instruction other than the in-line load completes in one clock and advances `prog_addr` by 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prog_addr | output | 8 | Program counter, address of the current instruction |
| prog_word | input | 16 | Program word at `prog_addr` |
| prog_next | input | 16 | Program word at `prog_addr`+1 |
| reg_view | output | 64 | Visible registers, register n in bits [16n+15:16n] |
| ovf_flag | output | 1 | Sticky stack overflow flag |
| unf_flag | output | 1 | Sticky stack underflow flag |

## Verification
The interesting collision is a push onto the destination's stack and a pop of the source's stack in one instruction. The source value must be read before the pop, while the old destination slides down its own stack. The bench provokes this with a move whose flags name both registers. It judges the result by the two visible values after that one clock, and later pops the destination to prove the old value was kept. The bench also names one register as both source and destination with its flag set. There it expects only the push, which a later pop makes visible.

// File: rtl/stkreg_pkg.sv
package stkreg_pkg;
  localparam int NREG    = 4;
  localparam int INSTR_W = 16;
  localparam logic [7:0] OP_LDI = 8'h08;

  typedef enum logic [2:0] {
    ALU_MOV = 3'd0,
    ALU_ADD = 3'd1,
    ALU_SUB = 3'd2,
    ALU_AND = 3'd3,
    ALU_OR  = 3'd4,
    ALU_XOR = 3'd5,
    ALU_SHL = 3'd6,
    ALU_SHR = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic [7:0]      op;
    logic [NREG-1:0] stk_en;
    logic [1:0]      src;
    logic [1:0]      dst;
  } instr_t;
endpackage

// File: rtl/stkreg_decode.sv
module stkreg_decode import stkreg_pkg::*; #(
  parameter int W = 16
) (
  input  instr_t          instr,
  output alu_op_e         alu_op,
  output logic            use_lit,
  output logic [W-1:0]    lit_val,
  output logic            is_ldi,
  output logic            do_write,
  output logic [NREG-1:0] push_v,
  output logic [NREG-1:0] pop_v
);
  logic lit_form;
  logic reg_form;

  always_comb begin
    lit_form = instr.op[7];
    reg_form = (instr.op[7:3] == 5'b0);
    is_ldi   = (instr.op == OP_LDI);
    do_write = lit_form | reg_form | is_ldi;
    use_lit  = lit_form;
    alu_op   = alu_op_e'(instr.op[2:0]);
    lit_val  = {{(W-4){instr.op[6]}}, instr.op[6:3]};
    push_v   = '0;
    pop_v    = '0;
    // destination push always wins over a pop of the same register
    push_v[instr.dst] = do_write & instr.stk_en[instr.dst];
    if (reg_form && (instr.src != instr.dst))
      pop_v[instr.src] = instr.stk_en[instr.src];
  end
endmodule

// File: rtl/stkreg_alu.sv
module stkreg_alu import stkreg_pkg::*; #(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam int SH_W = $clog2(W);
  logic [SH_W-1:0] sh;
  assign sh = b[SH_W-1:0];

  always_comb begin
    unique case (op)
      ALU_MOV: y = b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SHL: y = a << sh;
      ALU_SHR: y = a >> sh;
      default: y = b;
    endcase
  end
endmodule

// File: rtl/stkreg_stack.sv
module stkreg_stack #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] top,
  output logic         ovf_ev,
  output logic         unf_ev
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SP_W = $clog2(DEPTH + 1);
  localparam logic [SP_W-1:0] SP_FULL = SP_W'(DEPTH);

  logic [W-1:0]    mem [DEPTH];
  logic [SP_W-1:0] sp_q;
  logic [W-1:0]    top_q;
  logic            full, empty, do_push, do_pop;
  logic [AW-1:0]   wr_idx, rd_idx;

  assign full    = (sp_q == SP_FULL);
  assign empty   = (sp_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~push & ~empty;
  assign wr_idx  = AW'(sp_q);
  assign rd_idx  = AW'(sp_q - 1'b1);
  assign ovf_ev  = push & full;
  assign unf_ev  = pop & ~push & empty;
  assign top     = top_q;

  // storage below the top: no reset, single write port
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= top_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= '0;
      top_q <= '0;
    end else begin
      if (do_push)     sp_q <= sp_q + 1'b1;
      else if (do_pop) sp_q <= sp_q - 1'b1;
      if (wr_en)       top_q <= wr_val;
      else if (do_pop) top_q <= mem[rd_idx];
    end
  end

  assert_sp_bound_R9: assert property (@(posedge clk) disable iff (rst)
    sp_q <= SP_FULL);
  assert_full_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> (sp_q == SP_FULL));
  assert_empty_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && !wr_en && empty) |=> $stable(top_q));
  assert_pop_write_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(pop && wr_en));
endmodule

// File: rtl/stkreg_core.sv
module stkreg_core import stkreg_pkg::*; #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int PC_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  output logic [PC_W-1:0]     prog_addr,
  input  logic [INSTR_W-1:0]  prog_word,
  input  logic [INSTR_W-1:0]  prog_next,
  output logic [NREG*W-1:0]   reg_view,
  output logic                ovf_flag,
  output logic                unf_flag
);
  instr_t          ins;
  alu_op_e         alu_op;
  logic            use_lit, is_ldi, do_write;
  logic [W-1:0]    lit_val, opa, opb, alu_y, result;
  logic [NREG-1:0] push_v, pop_v, ovf_v, unf_v;
  logic [W-1:0]    tops [NREG];
  logic [PC_W-1:0] pc_q;
  logic            ovf_q, unf_q;

  assign ins = instr_t'(prog_word);

  stkreg_decode #(.W(W)) dec_i (
    .instr(ins), .alu_op(alu_op), .use_lit(use_lit), .lit_val(lit_val),
    .is_ldi(is_ldi), .do_write(do_write), .push_v(push_v), .pop_v(pop_v)
  );

  assign opa = tops[ins.dst];
  assign opb = use_lit ? lit_val : tops[ins.src];

  stkreg_alu #(.W(W)) alu_i (.op(alu_op), .a(opa), .b(opb), .y(alu_y));

  assign result = is_ldi ? W'(prog_next) : alu_y;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    stkreg_stack #(.W(W), .DEPTH(DEPTH)) stk_i (
      .clk(clk), .rst(rst),
      .push(push_v[g]), .pop(pop_v[g]),
      .wr_en(do_write && (ins.dst == 2'(g))), .wr_val(result),
      .top(tops[g]), .ovf_ev(ovf_v[g]), .unf_ev(unf_v[g])
    );
    assign reg_view[g*W +: W] = tops[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      pc_q  <= pc_q + (is_ldi ? PC_W'(2) : PC_W'(1));
      ovf_q <= ovf_q | (|ovf_v);
      unf_q <= unf_q | (|unf_v);
    end
  end

  assign prog_addr = pc_q;
  assign ovf_flag  = ovf_q;
  assign unf_flag  = unf_q;

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);
  assert_unf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    unf_flag |=> unf_flag);
  assert_ldi_step_R4: assert property (@(posedge clk) disable iff (rst)
    is_ldi |=> (prog_addr == $past(prog_addr) + PC_W'(2)));
  assert_plain_step_R12: assert property (@(posedge clk) disable iff (rst)
    !is_ldi |=> (prog_addr == $past(prog_addr) + PC_W'(1)));
  assert_single_push_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(push_v));
endmodule

// File: tb/stkreg_core_tb.sv
module stkreg_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  prog_addr;
  logic [15:0] prog_word, prog_next;
  logic [63:0] reg_view;
  logic        ovf_flag, unf_flag;
  logic [15:0] prog [256];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign prog_word = prog[prog_addr];
  assign prog_next = prog[8'(prog_addr + 8'd1)];

  stkreg_core dut_i (
    .clk(clk), .rst(rst), .prog_addr(prog_addr), .prog_word(prog_word),
    .prog_next(prog_next), .reg_view(reg_view),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  function automatic logic [15:0] ins(input logic [7:0] op, input logic [3:0] en,
                                      input logic [1:0] s, input logic [1:0] d);
    return {op, en, s, d};
  endfunction

  function automatic logic [15:0] rv(input int i);
    return reg_view[i*16 +: 16];
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = 16'h1000;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 pc", 16'(prog_addr), 16'h0);
    for (int i = 0; i < 4; i++) chk("R1 reg", rv(i), 16'h0);
    chk("R1 ovf", 16'(ovf_flag), 16'h0);
    chk("R1 unf", 16'(unf_flag), 16'h0);
  endtask

  task automatic t_alu();
    clear_prog();
    prog[0] = ins(8'h08, 4'h0, 2'd0, 2'd0); prog[1] = 16'h1234;
    prog[2] = ins(8'h08, 4'h0, 2'd0, 2'd1); prog[3] = 16'h00F0;
    prog[4] = ins(8'h00, 4'h0, 2'd0, 2'd2);
    prog[5] = ins(8'h01, 4'h0, 2'd1, 2'd2);
    prog[6] = ins(8'h05, 4'h0, 2'd1, 2'd0);
    prog[7] = ins(8'h02, 4'h0, 2'd0, 2'd1);
    prog[8] = ins(8'hA8, 4'h0, 2'd0, 2'd3);
    prog[9] = ins(8'h06, 4'h0, 2'd3, 2'd0);
    prog[10] = ins(8'h03, 4'h0, 2'd1, 2'd2);
    prog[11] = ins(8'h07, 4'h0, 2'd3, 2'd1);
    prog[12] = ins(8'h04, 4'h0, 2'd2, 2'd3);
    do_reset();
    step(5);
    chk("R4 pc after two loads", 16'(prog_addr), 16'd7);
    chk("R2 add", rv(2), 16'h1324);
    chk("R2 xor", rv(0), 16'h12C4);
    step(6);
    chk("R12 pc", 16'(prog_addr), 16'd13);
    chk("R2 shl", rv(0), 16'h5880);
    chk("R2 sub shr", rv(1), 16'h0771);
    chk("R2 and", rv(2), 16'h0224);
    chk("R3 mov lit or", rv(3), 16'h0225);
  endtask

  task automatic t_lit();
    clear_prog();
    prog[0] = ins(8'h08, 4'h0, 2'd0, 2'd0); prog[1] = 16'h0010;
    prog[2] = ins(8'hE9, 4'h0, 2'd0, 2'd0);
    prog[3] = ins(8'hC2, 4'h0, 2'd0, 2'd0);
    prog[4] = ins(8'hB8, 4'b0100, 2'd2, 2'd1);
    do_reset();
    step(2);
    chk("R3 add -3", rv(0), 16'h000D);
    step(2);
    chk("R3 sub -8", rv(0), 16'h0015);
    chk("R3 mov 7", rv(1), 16'h0007);
    chk("R8 lit form no pop", 16'(unf_flag), 16'h0);
    chk("R12 pc", 16'(prog_addr), 16'd5);
  endtask

  task automatic t_stack();
    clear_prog();
    prog[0] = ins(8'h08, 4'h0, 2'd0, 2'd0); prog[1] = 16'h00AA;
    prog[2] = ins(8'h08, 4'b0001, 2'd0, 2'd0); prog[3] = 16'h00BB;
    prog[4] = ins(8'h08, 4'h0, 2'd0, 2'd1); prog[5] = 16'h0011;
    prog[6] = ins(8'h00, 4'b0011, 2'd0, 2'd1);
    prog[7] = ins(8'h00, 4'b0010, 2'd1, 2'd0);
    prog[8] = ins(8'h01, 4'b0010, 2'd1, 2'd1);
    prog[9] = ins(8'h00, 4'b0010, 2'd1, 2'd2);
    prog[10] = ins(8'h00, 4'b0001, 2'd2, 2'd3);
    prog[11] = ins(8'h00, 4'b0001, 2'd0, 2'd2);
    do_reset();
    step(4);
    chk("R6 same-cycle pop src", rv(0), 16'h00AA);
    chk("R5 same-cycle dst write", rv(1), 16'h00BB);
    chk("R4 pc", 16'(prog_addr), 16'd7);
    step(1);
    chk("R5 overwrite no push", rv(0), 16'h00BB);
    chk("R5 pushed old dst popped", rv(1), 16'h0011);
    step(2);
    chk("R7 push only then pop", rv(1), 16'h0011);
    chk("R7 doubled value", rv(2), 16'h0022);
    step(1);
    chk("R8 move", rv(3), 16'h0022);
    chk("R8 uninvolved flag", rv(0), 16'h00BB);
    chk("R8 no underflow", 16'(unf_flag), 16'h0);
    step(1);
    chk("R10 reg held", rv(0), 16'h00BB);
    chk("R10 flag", 16'(unf_flag), 16'h1);
    chk("R10 dst still written", rv(2), 16'h00BB);
  endtask

  task automatic t_ovf();
    clear_prog();
    for (int k = 0; k < 9; k++) prog[k] = ins(8'h89, 4'b1000, 2'd0, 2'd3);
    for (int k = 9; k < 18; k++) prog[k] = ins(8'h00, 4'b1000, 2'd3, 2'd2);
    do_reset();
    step(8);
    chk("R9 eight pushes", rv(3), 16'd8);
    chk("R9 no ovf yet", 16'(ovf_flag), 16'h0);
    step(1);
    chk("R9 reg written", rv(3), 16'd9);
    chk("R9 ovf set", 16'(ovf_flag), 16'h1);
    step(1);
    chk("R9 top kept", rv(3), 16'd7);
    chk("R6 src read before pop", rv(2), 16'd9);
    step(7);
    chk("R9 bottom", rv(3), 16'd0);
    chk("R10 no unf yet", 16'(unf_flag), 16'h0);
    step(1);
    chk("R10 unf set", 16'(unf_flag), 16'h1);
    chk("R10 reg held", rv(3), 16'd0);
    chk("R9 sticky", 16'(ovf_flag), 16'h1);
  endtask

  task automatic t_undef();
    clear_prog();
    prog[0] = ins(8'h08, 4'h0, 2'd0, 2'd0); prog[1] = 16'h5555;
    prog[2] = ins(8'h10, 4'hF, 2'd0, 2'd1);
    prog[3] = ins(8'h7F, 4'hF, 2'd1, 2'd0);
    do_reset();
    step(3);
    chk("R11 r0", rv(0), 16'h5555);
    chk("R11 r1", rv(1), 16'h0000);
    chk("R11 flags", {14'h0, ovf_flag, unf_flag}, 16'h0);
    chk("R11 pc", 16'(prog_addr), 16'd4);
  endtask

  initial begin
    clear_prog();
    do_reset();
    t_reset();
    t_alu();
    t_lit();
    t_stack();
    t_ovf();
    do_reset();
    t_reset();
    t_undef();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R12 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule